// File: doc/BRIEF.md
# Warp Issue Scheduler with Barrier Collection

This block decides which warp fetches next in a single-issue SIMT core. The IDs of warps that are ready to run wait in a circular queue. Whenever the queue holds an entry, the block issues the ID at its head to instruction fetch. It issues one warp per cycle at most. An issued warp is absent from the queue for as long as its fetch is in flight. When fetch reports that the warp has completed, the ID goes back in at the tail. This gives round-robin ordering without a separate arbiter.

When fetch reports completion with the barrier flag set, the warp is parked and does not return to the queue. The block compares the number of parked warps with the number of active warps. Once they are equal, it releases all parked warps back into the queue in ascending ID order, one per cycle. A spawn input activates a warp that is not yet running and places its ID in the queue.

Top module: `warp_sched`

## Requirements
- R1: In the first cycle after a synchronous reset, only warp 0 is active (`active_o` = 1) and the queue holds only warp 0, so `issue_vld_o`=1 with `issue_wid_o`=0.
- R2: `issue_vld_o` is high exactly when the queue is non-empty. When it is high, the head ID is shown and leaves the queue at that clock edge. An empty queue stalls issue.
- R3: An issued warp is not issued again until `fetch_done_i` reports it. A report with `fetch_bar_i`=0 appends the ID at the queue tail, and the ID becomes issuable from the next cycle in FIFO order.
- R4: A spawn of an in-range, inactive ID sets its bit in `active_o` from the next cycle and enqueues it. A spawn of an already active ID changes nothing. Active bits never clear outside reset.
- R5: A completion report with `fetch_bar_i`=1 parks the warp. The warp is not enqueued and stays out of issue until the barrier releases.
- R6: When the registered number of parked warps is non-zero and equals the number of active warps, the barrier fires. Starting one cycle later, the parked IDs are enqueued one per cycle in ascending ID order.
- R7: When several IDs enter the queue at the same edge, they are placed in this order: the completed fetch warp, then the spawned warp, then the barrier release.
- R8: The queue never holds more than NUM_WARPS entries, and no warp is both queued and outstanding.
- R9: A spawn whose ID is NUM_WARPS or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_done_i | input | 1 | Fetch completion for one in-flight warp |
| fetch_wid_i | input | WID_W | ID of the completing warp |
| fetch_bar_i | input | 1 | Completed instruction is a barrier |
| spawn_i | input | 1 | Request to activate a warp |
| spawn_wid_i | input | WID_W | ID to activate |
| issue_vld_o | output | 1 | A warp is issued this cycle |
| issue_wid_o | output | WID_W | ID of the issued warp |
| active_o | output | NUM_WARPS | Mask of active warps |

## Verification
The bench builds the block with NUM_WARPS = 6. This makes the queue depth a non-power of two, so the pointer wrap is exercised at an uneven boundary. The 3-bit ID field can encode 6 and 7, which are beyond the last warp, so out-of-range spawns can be driven directly. With only six warps, random barrier arrivals fill the barrier often. Releases therefore coincide with completions and spawns at the same edge, which exercises the push ordering.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    // Sources that may append to the ready queue in one cycle, in push order.
    typedef enum int {
        SRC_FETCH = 0,
        SRC_SPAWN = 1,
        SRC_REL   = 2
    } push_src_e;

    localparam int PUSH_PORTS = 3;

    // Advance a ring pointer by k slots, wrapping at depth.
    function automatic int ring_adv(input int p, input int k, input int depth);
        return (p + k) % depth;
    endfunction

endpackage

// File: rtl/warp_ready_ring.sv
module warp_ready_ring
    import warp_sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WID_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_vld [PUSH_PORTS],
    input  logic [WID_W-1:0] push_wid [PUSH_PORTS],
    output logic             head_vld,
    output logic [WID_W-1:0] head_wid
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WID_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic [CNT_W-1:0] cnt_q;

    int slot_off [PUSH_PORTS];
    int n_push;

    // Offset of each push from the tail, counting only valid earlier ports.
    always_comb begin
        n_push = 0;
        for (int j = 0; j < PUSH_PORTS; j++) begin
            slot_off[j] = n_push;
            if (push_vld[j]) n_push = n_push + 1;
        end
    end

    assign head_vld = (cnt_q != '0);
    assign head_wid = slot_q[head_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) slot_q[s] <= '0;
            head_q <= '0;
            tail_q <= PTR_W'(ring_adv(0, 1, DEPTH));
            cnt_q  <= CNT_W'(1);
        end else begin
            for (int j = 0; j < PUSH_PORTS; j++) begin
                if (push_vld[j])
                    slot_q[PTR_W'(ring_adv(int'(tail_q), slot_off[j], DEPTH))] <= push_wid[j];
            end
            tail_q <= PTR_W'(ring_adv(int'(tail_q), n_push, DEPTH));
            if (head_vld) head_q <= PTR_W'(ring_adv(int'(head_q), 1, DEPTH));
            cnt_q <= CNT_W'(int'(cnt_q) + n_push - (head_vld ? 1 : 0));
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH); // R8

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (head_vld && n_push == 0) |=> (int'(cnt_q) == int'($past(cnt_q)) - 1)); // R2

endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
    parameter int NW    = 8,
    parameter int WID_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arrive_vld,
    input  logic [WID_W-1:0] arrive_wid,
    input  logic [NW-1:0]    active_mask,
    output logic             rel_vld,
    output logic [WID_W-1:0] rel_wid
);
    logic [NW-1:0] parked_q;
    logic [NW-1:0] drain_q;
    logic [NW-1:0] arr_bits;
    logic [NW-1:0] rel_bit;
    int            n_park;
    int            n_act;
    logic          fire;

    always_comb begin
        n_park = 0;
        n_act  = 0;
        for (int i = 0; i < NW; i++) begin
            if (parked_q[i])    n_park = n_park + 1;
            if (active_mask[i]) n_act  = n_act + 1;
            arr_bits[i] = arrive_vld && (arrive_wid == WID_W'(i));
        end
        fire = (drain_q == '0) && (n_park != 0) && (n_park == n_act);
    end

    // Lowest pending ID is released first.
    always_comb begin
        rel_wid = '0;
        rel_bit = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (drain_q[i]) rel_wid = WID_W'(i);
        end
        for (int i = 0; i < NW; i++) rel_bit[i] = rel_vld && (rel_wid == WID_W'(i));
    end

    assign rel_vld = |drain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            parked_q <= '0;
            drain_q  <= '0;
        end else begin
            parked_q <= (fire ? '0 : parked_q) | arr_bits;
            drain_q  <= fire ? parked_q : (drain_q & ~rel_bit);
        end
    end

    AST_PARK_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (parked_q & ~active_mask) == '0); // R5

    AST_REL_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (rel_vld && $past(rel_vld)) |-> (rel_wid > $past(rel_wid))); // R6

    AST_PARK_DRAIN_APART: assert property (@(posedge clk) disable iff (rst)
        (parked_q & drain_q) == '0); // R6

endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch_done_i,
    input  logic [WID_W-1:0]     fetch_wid_i,
    input  logic                 fetch_bar_i,
    input  logic                 spawn_i,
    input  logic [WID_W-1:0]     spawn_wid_i,
    output logic                 issue_vld_o,
    output logic [WID_W-1:0]     issue_wid_o,
    output logic [NUM_WARPS-1:0] active_o
);
    logic [NUM_WARPS-1:0] active_q;
    logic                 spawn_ok;
    logic                 rel_vld;
    logic [WID_W-1:0]     rel_wid;
    logic                 push_vld [PUSH_PORTS];
    logic [WID_W-1:0]     push_wid [PUSH_PORTS];

    // Spawn accepted only for an in-range ID that is not running yet (R4, R9).
    always_comb begin
        spawn_ok = 1'b0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (spawn_i && spawn_wid_i == WID_W'(i) && !active_q[i]) spawn_ok = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= NUM_WARPS'(1);
        end else begin
            for (int i = 0; i < NUM_WARPS; i++) begin
                if (spawn_ok && spawn_wid_i == WID_W'(i)) active_q[i] <= 1'b1;
            end
        end
    end

    // Push ports in tail order: completed fetch, spawn, barrier release (R7).
    always_comb begin
        push_vld[SRC_FETCH] = fetch_done_i && !fetch_bar_i;
        push_wid[SRC_FETCH] = fetch_wid_i;
        push_vld[SRC_SPAWN] = spawn_ok;
        push_wid[SRC_SPAWN] = spawn_wid_i;
        push_vld[SRC_REL]   = rel_vld;
        push_wid[SRC_REL]   = rel_wid;
    end

    warp_ready_ring #(
        .DEPTH (NUM_WARPS),
        .WID_W (WID_W)
    ) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push_vld (push_vld),
        .push_wid (push_wid),
        .head_vld (issue_vld_o),
        .head_wid (issue_wid_o)
    );

    warp_barrier #(
        .NW    (NUM_WARPS),
        .WID_W (WID_W)
    ) u_bar (
        .clk         (clk),
        .rst         (rst),
        .arrive_vld  (fetch_done_i && fetch_bar_i),
        .arrive_wid  (fetch_wid_i),
        .active_mask (active_q),
        .rel_vld     (rel_vld),
        .rel_wid     (rel_wid)
    );

    assign active_o = active_q;

    AST_RESET_HEAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (issue_vld_o && issue_wid_o == '0 && active_q == NUM_WARPS'(1))); // R1

    AST_ISSUE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        issue_vld_o |-> active_q[issue_wid_o]); // R2

    AST_ACTIVE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (active_q & $past(active_q)) == $past(active_q)); // R4

    AST_BAD_SPAWN: assert property (@(posedge clk) disable iff (rst)
        (spawn_i && int'(spawn_wid_i) >= NUM_WARPS) |=> (active_q == $past(active_q))); // R9

endmodule

// File: tb/warp_sched_bench.sv
module warp_sched_bench;
    localparam int NW   = 6;
    localparam int WIDW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            fetch_done_i = 1'b0;
    logic [WIDW-1:0] fetch_wid_i = '0;
    logic            fetch_bar_i = 1'b0;
    logic            spawn_i = 1'b0;
    logic [WIDW-1:0] spawn_wid_i = '0;
    logic            issue_vld_o;
    logic [WIDW-1:0] issue_wid_o;
    logic [NW-1:0]   active_o;

    always #5 clk = ~clk;

    warp_sched #(.NUM_WARPS(NW)) u_warp_sched (
        .clk          (clk),
        .rst          (rst),
        .fetch_done_i (fetch_done_i),
        .fetch_wid_i  (fetch_wid_i),
        .fetch_bar_i  (fetch_bar_i),
        .spawn_i      (spawn_i),
        .spawn_wid_i  (spawn_wid_i),
        .issue_vld_o  (issue_vld_o),
        .issue_wid_o  (issue_wid_o),
        .active_o     (active_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Behavioural reference state.
    int q[$];
    int relq[$];
    int outst[$];
    bit mact[NW];
    bit mpark[NW];

    int    fd_pct, bar_pct, sp_pct;
    string tag;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pc(input bit m[NW]);
        int c = 0;
        for (int i = 0; i < NW; i++) c += m[i];
        return c;
    endfunction

    task automatic compare_outputs();
        logic [NW-1:0] em;
        for (int i = 0; i < NW; i++) em[i] = mact[i];
        check(issue_vld_o == (q.size() > 0), tag, int'(issue_vld_o), int'(q.size() > 0));
        if (q.size() > 0 && issue_vld_o)
            check(int'(issue_wid_o) == q[0], tag, int'(issue_wid_o), q[0]);
        check(active_o == em, tag, int'(active_o), int'(em));
    endtask

    // Drive one cycle of stimulus and advance the model to the post-edge state.
    task automatic step();
        bit fd = 0, br = 0, sp = 0, fire, sp_ok;
        int fw = 0, sw = 0, iss = -1, rp = -1;
        bit old_park[NW];
        if (outst.size() > 0 && ($urandom % 100) < fd_pct) begin
            int k = int'($urandom % outst.size());
            fd = 1; fw = outst[k]; outst.delete(k);
            br = (($urandom % 100) < bar_pct);
        end
        if (($urandom % 100) < sp_pct) begin
            sp = 1; sw = int'($urandom % 8);
        end
        fetch_done_i = fd; fetch_wid_i = WIDW'(fw); fetch_bar_i = br;
        spawn_i = sp; spawn_wid_i = WIDW'(sw);

        old_park = mpark;
        fire = (relq.size() == 0) && (pc(mpark) != 0) && (pc(mpark) == pc(mact));
        if (q.size() > 0) iss = q.pop_front();
        if (relq.size() > 0) rp = relq.pop_front();
        if (fire) for (int i = 0; i < NW; i++) mpark[i] = 0;
        if (fd && br) mpark[fw] = 1;                 // R5
        if (fd && !br) q.push_back(fw);              // R3, R7 first
        sp_ok = sp && (sw < NW) && !mact[sw];        // R4, R9
        if (sp_ok) begin mact[sw] = 1; q.push_back(sw); end
        if (rp >= 0) q.push_back(rp);                // R7 last
        if (fire) for (int i = 0; i < NW; i++) if (old_park[i]) relq.push_back(i); // R6
        if (iss >= 0) begin
            bit dup = 0;
            foreach (outst[k]) if (outst[k] == iss) dup = 1;
            check(!dup && !mpark[iss], "R8", iss, -1);
            outst.push_back(iss);
        end
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare_outputs();
            step();
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin mact[i] = (i == 0); mpark[i] = 0; end
        q.push_back(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R1";
        compare_outputs();
        fd_pct = 100; bar_pct = 0; sp_pct = 0;
        step();
        tag = "R2/R3";
        run(40);
        fd_pct = 60; sp_pct = 30;
        tag = "R4/R9";
        run(80);
        fd_pct = 70; bar_pct = 20; sp_pct = 10;
        tag = "R5/R6/R7";
        run(2000);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule